// File: doc/BRIEF.md
# Adaptive-Gain Loop Filter for a Digital PLL

This block is the loop filter of an all-digital phase-locked loop, bundled with the logic that tunes the filter gain. Each reference cycle the phase detector sends a one-cycle strobe and a signed 6-bit phase-error word. On that strobe the filter updates a 17-bit signed control word for the oscillator decoder. It uses a proportional-integral recursion with a lag of four updates: each new output equals the output from four updates earlier, plus the gain times the difference between the present error and 0.8 times the error from four updates earlier.

The gain is a 9-bit unsigned value that changes by one step on every update. When the magnitude of the error is above a programmable threshold, the gain rises by one, which speeds up pull-in. When the magnitude is at or below the threshold, the gain falls by one, which lowers the loop bandwidth near lock. The result is always limited to a floor and a ceiling that software can change at run time. The constant 0.8 is approximated without a multiplier as 51/64.

Top module: `alf_loop_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `ctrl_word` to 0, clears both four-entry history lines, and loads `gain_now` with `gain_max`. The first four updates after reset therefore see zero for the lagged error and the lagged output.
- R2: The block changes `ctrl_word` and `gain_now` only at an edge where `upd_stb` is high. Without a strobe, changes on `phase_err`, `err_thresh`, `gain_min` or `gain_max` have no effect on either output.
- R3: After the edge that samples a strobe, `ctrl_word` holds y[n] = sat(y[n-4] + floor(G·(64·x[n] − 51·x[n-4]) / 64)). Here x is `phase_err` read as two's complement, n counts strobes rather than clock cycles, and G is the `gain_now` value visible before that strobe.
- R4: After a strobe, `gain_now` becomes G+1 when |x[n]| > `err_thresh` (unsigned), and otherwise G−1. G−1 from 0 stays at 0. An error equal to the threshold counts as not exceeding it, and −32 has magnitude 32.
- R5: The stepped gain is limited as min(max(candidate, `gain_min`), `gain_max`). When `gain_min` exceeds `gain_max`, the result is `gain_max`. A bound changed between strobes applies at the next strobe.
- R6: The sum in R3 saturates at +65535 and −65536 and never wraps.
- R7: The output update and the gain step happen on the same strobe. The output uses the old gain, and the new gain becomes visible on the same edge as the new output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_stb | input | 1 | One-cycle strobe marking a new phase-error sample |
| phase_err | input | 6 | Signed phase-error word |
| err_thresh | input | 6 | Unsigned magnitude threshold for gain stepping |
| gain_min | input | 9 | Lower gain bound |
| gain_max | input | 9 | Upper gain bound, also the gain loaded at reset |
| ctrl_word | output | 17 | Signed frequency control word |
| gain_now | output | 9 | Present filter gain |

## Verification
The filter update and the gain step happen on the same strobe. A wrong choice of which gain feeds the product is the error most likely to hide, because the two values differ by only one step. The bench sets the gain below the ceiling and sends errors above the threshold, so every strobe both changes the output and raises the gain. The bench model computes each output from the gain it recorded before that strobe, so a design that uses the new gain fails the output check. Saturation and the gain clamp are also made to coincide: long runs at full scale pin the gain at the ceiling while the accumulators reach their limits.

// File: rtl/alf_pkg.sv
package alf_pkg;
  localparam int ALF_XW   = 6;   // phase-error width
  localparam int ALF_GW   = 9;   // gain width
  localparam int ALF_YW   = 17;  // control word width
  localparam int ALF_LAG  = 4;   // recursion lag in updates
  localparam int ALF_FRAC = 6;   // fraction bits of the 0.8 approximation (51/64)

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HIGH = 2'd1,
    SAT_LOW  = 2'd2
  } sat_e;
endpackage

// File: rtl/alf_delay_line.sv
module alf_delay_line #(
  parameter int W     = 17,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] newest,
  output logic [W-1:0] oldest
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else if (en) stage[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else if (en) stage[i] <= stage[i-1];
    end
  end

  assign newest = stage[0];
  assign oldest = stage[DEPTH-1];

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(newest) && $stable(oldest));
endmodule

// File: rtl/alf_gain_ctrl.sv
module alf_gain_ctrl #(
  parameter int XW = 6,
  parameter int GW = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [XW-1:0] err,
  input  logic [XW-1:0]        thresh,
  input  logic [GW-1:0]        g_floor,
  input  logic [GW-1:0]        g_ceil,
  output logic [GW-1:0]        gain,
  output logic                 over_thr
);
  localparam int MW = XW + 1;

  function automatic logic [MW-1:0] mag_of(input logic signed [XW-1:0] v);
    logic [MW-1:0] w;
    w = {v[XW-1], v};
    return w[MW-1] ? MW'(~w + 1'b1) : w;
  endfunction

  function automatic logic [GW-1:0] next_gain(input logic [GW-1:0] g, input logic up,
                                              input logic [GW-1:0] lo, input logic [GW-1:0] hi);
    logic [GW:0] c;
    if (up) c = {1'b0, g} + (GW+1)'(1);
    else if (g == '0) c = '0;
    else c = {1'b0, g} - (GW+1)'(1);
    if (c < {1'b0, lo}) c = {1'b0, lo};
    if (c > {1'b0, hi}) c = {1'b0, hi};
    return c[GW-1:0];
  endfunction

  logic [MW-1:0] err_mag;
  logic [GW-1:0] gain_cand;

  assign err_mag   = mag_of(err);
  assign over_thr  = err_mag > {1'b0, thresh};
  assign gain_cand = next_gain(gain, over_thr, g_floor, g_ceil);

  always_ff @(posedge clk) begin
    if (rst) gain <= g_ceil;
    else if (upd) gain <= gain_cand;
  end

  // R1
  gain_reset_chk: assert property (@(posedge clk)
    rst |=> gain == $past(g_ceil));
  // R5
  gain_ceil_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> gain <= $past(g_ceil));
  // R2
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(gain));
  // R4
  gain_rise_chk: assert property (@(posedge clk) disable iff (rst)
    upd && over_thr && ({1'b0, gain} + (GW+1)'(1) <= {1'b0, g_ceil}) && (gain >= g_floor)
    |=> gain == $past(gain) + GW'(1));
endmodule

// File: rtl/alf_filter_core.sv
module alf_filter_core
  import alf_pkg::*;
#(
  parameter int XW = 6,
  parameter int GW = 9,
  parameter int YW = 17
) (
  input  logic signed [XW-1:0] x_now,
  input  logic signed [XW-1:0] x_lag,
  input  logic signed [YW-1:0] y_lag,
  input  logic [GW-1:0]        g,
  output logic signed [YW-1:0] y_next,
  output logic                 term_neg,
  output sat_e                 sat_state
);
  localparam int FRAC = ALF_FRAC;
  localparam int EW   = XW + FRAC + 2;
  localparam int PW   = EW + GW + 1;
  localparam int TW   = PW - FRAC;
  localparam int SW   = ((TW > YW) ? TW : YW) + 1;
  localparam logic signed [SW-1:0] YMAX = SW'((2 ** (YW - 1)) - 1);
  localparam logic signed [SW-1:0] YMIN = -SW'(2 ** (YW - 1));

  // 64*a - 51*b, with 51 = 64 - 16 + 2 + 1 (x - x/4 + x/32 + x/64 at 2^FRAC scale)
  function automatic logic signed [EW-1:0] weighted_diff(input logic signed [XW-1:0] a,
                                                         input logic signed [XW-1:0] b);
    logic signed [EW-1:0] ae, be;
    ae = EW'(a);
    be = EW'(b);
    return (ae <<< FRAC) - ((be <<< FRAC) - (be <<< (FRAC - 2)) + (be <<< (FRAC - 5)) + (be <<< (FRAC - 6)));
  endfunction

  function automatic logic signed [TW-1:0] scaled_term(input logic [GW-1:0] gv,
                                                      input logic signed [EW-1:0] e);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] s;
    p = PW'($signed({1'b0, gv})) * PW'(e);
    s = p >>> FRAC;
    return s[TW-1:0];
  endfunction

  logic signed [EW-1:0] diff;
  logic signed [TW-1:0] term;
  logic signed [SW-1:0] sum;

  assign diff     = weighted_diff(x_now, x_lag);
  assign term     = scaled_term(g, diff);
  assign sum      = SW'(y_lag) + SW'(term);
  assign term_neg = term[TW-1];

  always_comb begin
    if (sum > YMAX) begin
      sat_state = SAT_HIGH;
      y_next    = YMAX[YW-1:0];
    end else if (sum < YMIN) begin
      sat_state = SAT_LOW;
      y_next    = YMIN[YW-1:0];
    end else begin
      sat_state = SAT_NONE;
      y_next    = sum[YW-1:0];
    end
  end
endmodule

// File: rtl/alf_loop_filter.sv
module alf_loop_filter
  import alf_pkg::*;
#(
  parameter int XW  = ALF_XW,
  parameter int GW  = ALF_GW,
  parameter int YW  = ALF_YW,
  parameter int LAG = ALF_LAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_stb,
  input  logic [XW-1:0] phase_err,
  input  logic [XW-1:0] err_thresh,
  input  logic [GW-1:0] gain_min,
  input  logic [GW-1:0] gain_max,
  output logic [YW-1:0] ctrl_word,
  output logic [GW-1:0] gain_now
);
  logic [XW-1:0] x_newest, x_lag;
  logic [YW-1:0] y_lag;
  logic signed [YW-1:0] y_next;
  logic          term_neg;
  logic          over_thr;
  sat_e          sat_state;

  alf_delay_line #(.W(XW), .DEPTH(LAG)) u_x_line (
    .clk(clk), .rst(rst), .en(upd_stb), .d(phase_err),
    .newest(x_newest), .oldest(x_lag)
  );

  alf_delay_line #(.W(YW), .DEPTH(LAG)) u_y_line (
    .clk(clk), .rst(rst), .en(upd_stb), .d(y_next),
    .newest(ctrl_word), .oldest(y_lag)
  );

  alf_gain_ctrl #(.XW(XW), .GW(GW)) u_gain (
    .clk(clk), .rst(rst), .upd(upd_stb), .err(phase_err), .thresh(err_thresh),
    .g_floor(gain_min), .g_ceil(gain_max), .gain(gain_now), .over_thr(over_thr)
  );

  alf_filter_core #(.XW(XW), .GW(GW), .YW(YW)) u_core (
    .x_now(phase_err), .x_lag(x_lag), .y_lag(y_lag), .g(gain_now),
    .y_next(y_next), .term_neg(term_neg), .sat_state(sat_state)
  );

  // R3
  out_track_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> ctrl_word == $past(y_next));
  // R6
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb && !term_neg |=> $signed(ctrl_word) >= $signed($past(y_lag)));
  // R6
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb && term_neg |=> $signed(ctrl_word) <= $signed($past(y_lag)));
  // R1
  out_reset_chk: assert property (@(posedge clk)
    rst |=> ctrl_word == '0);
endmodule

// File: tb/alf_loop_filter_bench.sv
module alf_loop_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_stb = 1'b0;
  logic [5:0] phase_err = '0;
  logic [5:0] err_thresh = 6'd8;
  logic [8:0] gain_min = 9'd4;
  logic [8:0] gain_max = 9'd40;
  logic [16:0] ctrl_word;
  logic [8:0]  gain_now;

  int checks = 0;
  int errors = 0;
  int mx [4];
  int my [4];
  int mg;

  always #(CLK_PERIOD/2) clk = ~clk;

  alf_loop_filter u_alf_loop_filter (
    .clk(clk), .rst(rst), .upd_stb(upd_stb), .phase_err(phase_err),
    .err_thresh(err_thresh), .gain_min(gain_min), .gain_max(gain_max),
    .ctrl_word(ctrl_word), .gain_now(gain_now)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin mx[i] = 0; my[i] = 0; end
    mg = int'(gain_max);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 ctrl after reset", $signed(ctrl_word), 0);
    check("R1 gain after reset", int'(gain_now), mg);
  endtask

  // one strobe, then compare against the model; req names the requirement judged
  task automatic strobe(input int x, input string req);
    int e, t, y, mag, cand;
    @(negedge clk);
    phase_err = 6'(x);
    upd_stb = 1'b1;
    @(negedge clk);
    upd_stb = 1'b0;
    e = 64 * x - 51 * mx[3];
    t = (mg * e) >>> 6;
    y = my[3] + t;
    if (y > 65535) y = 65535;
    if (y < -65536) y = -65536;
    for (int i = 3; i > 0; i--) begin mx[i] = mx[i-1]; my[i] = my[i-1]; end
    mx[0] = x;
    my[0] = y;
    mag = (x < 0) ? -x : x;
    if (mag > int'(err_thresh)) cand = mg + 1;
    else cand = (mg == 0) ? 0 : mg - 1;
    if (cand < int'(gain_min)) cand = int'(gain_min);
    if (cand > int'(gain_max)) cand = int'(gain_max);
    mg = cand;
    check({req, " ctrl"}, $signed(ctrl_word), y);
    check({req, " gain"}, int'(gain_now), mg);
  endtask

  task automatic t_gain_down();
    err_thresh = 6'd10; gain_min = 9'd30; gain_max = 9'd40;
    do_reset();
    for (int k = 0; k < 14; k++) strobe(3, "R4 below thresh");
    check("R5 floor reached", int'(gain_now), 30);
  endtask

  task automatic t_gain_up();
    gain_min = 9'd0; gain_max = 9'd60; err_thresh = 6'd2;
    do_reset();
    for (int k = 0; k < 5; k++) strobe(1, "R4 down to 55");
    for (int k = 0; k < 8; k++) strobe(-9, "R7 rise with old gain");
    check("R5 ceiling reached", int'(gain_now), 60);
  endtask

  task automatic t_equal_and_extreme();
    err_thresh = 6'd7; gain_min = 9'd0; gain_max = 9'd100;
    do_reset();
    strobe(7, "R4 equal thresh steps down");
    strobe(-7, "R4 equal negative steps down");
    strobe(8, "R4 above thresh steps up");
    err_thresh = 6'd31;
    strobe(-32, "R4 minus32 magnitude");
    strobe(31, "R4 31 not above 31");
  endtask

  task automatic t_floor_zero();
    err_thresh = 6'd20; gain_min = 9'd0; gain_max = 9'd2;
    do_reset();
    for (int k = 0; k < 4; k++) strobe(5, "R4 gain stays at zero");
    check("R4 zero floor", int'(gain_now), 0);
  endtask

  task automatic t_filter_mix();
    err_thresh = 6'd12; gain_min = 9'd16; gain_max = 9'd200;
    do_reset();
    strobe(13, "R3 seq");  strobe(-20, "R3 seq"); strobe(5, "R3 seq");
    strobe(0, "R3 seq");   strobe(-1, "R3 seq");  strobe(31, "R3 seq");
    strobe(-32, "R3 seq"); strobe(17, "R3 seq");  strobe(-5, "R3 seq");
    strobe(2, "R3 seq");   strobe(-14, "R3 seq"); strobe(9, "R3 seq");
  endtask

  task automatic t_idle();
    int c0, g0;
    c0 = $signed(ctrl_word); g0 = int'(gain_now);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      phase_err = 6'(k * 11);
      err_thresh = 6'(k);
      gain_min = 9'(300 + k);
      gain_max = 9'(k);
    end
    @(negedge clk);
    check("R2 ctrl held without strobe", $signed(ctrl_word), c0);
    check("R2 gain held without strobe", int'(gain_now), g0);
    err_thresh = 6'd12; gain_min = 9'd16; gain_max = 9'd200;
    strobe(4, "R2 history unchanged by idle");
  endtask

  task automatic t_bounds_runtime();
    err_thresh = 6'd3; gain_min = 9'd0; gain_max = 9'd120;
    do_reset();
    strobe(10, "R5 at ceiling");
    gain_max = 9'd50;
    strobe(10, "R5 lowered ceiling applies");
    check("R5 new ceiling", int'(gain_now), 50);
    gain_min = 9'd90; gain_max = 9'd70;
    strobe(0, "R5 inverted bounds ceiling wins");
    check("R5 inverted bounds", int'(gain_now), 70);
  endtask

  task automatic t_saturate();
    err_thresh = 6'd0; gain_min = 9'd511; gain_max = 9'd511;
    do_reset();
    for (int k = 0; k < 80; k++) strobe(31, "R6 positive limit");
    check("R6 top limit", $signed(ctrl_word), 65535);
    for (int k = 0; k < 220; k++) strobe(-32, "R6 negative limit");
    check("R6 bottom limit", $signed(ctrl_word), -65536);
  endtask

  task automatic t_reset_mid();
    err_thresh = 6'd5; gain_min = 9'd1; gain_max = 9'd33;
    do_reset();
    strobe(-6, "R1 first after reset");
    strobe(20, "R1 history zero");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_gain_down();
    t_gain_up();
    t_equal_and_extreme();
    t_floor_zero();
    t_filter_mix();
    t_idle();
    t_bounds_runtime();
    t_saturate();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule